// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Conditioning

This block is a 32-pin general-purpose I/O bank behind a plain word-wide register port. Software chooses the direction of each pin, reads the synchronised pin levels and drives the outputs. The output register can be written as a whole word. It can also be changed through a set register, where 1 bits are set and 0 bits are kept, and through a clear register, where 1 bits are cleared and 0 bits are kept. A direction bit of 1 makes a pin an output. A direction bit of 0 releases the pin, and this is shown on a separate output-enable vector.

Each of the lowest 16 pins drives its own active-high interrupt line to a downstream interrupt controller. A line has no polarity register. In level mode the output data bit of the pin sets the polarity: 0 passes the synchronised pin straight through, and 1 inverts it. Setting the mode bit of the line selects both-edge mode. In that mode any change of the synchronised pin sets a sticky pending bit, and the line stays high until software writes a 1 to the acknowledge register. Changing the output bit or the mode bit of a line discards its pending state.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset, the direction, output and mode registers read as zero, `pin_oe` and `pin_out` are all zero, and `irq` is zero.
- R2: A write to offset 0x00 loads the direction register, and `pin_oe` follows it from the next cycle. A write to offset 0x10 loads the output register, and `pin_out` follows it from the next cycle. Both registers read back at their offsets.
- R3: At offset 0x18, each 1 bit of the written word sets the matching output bit. At offset 0x20, each 1 bit clears the matching output bit. Output bits under 0 bits of the written word keep their value.
- R4: A read at offset 0x08 returns `pin_in` after a two-flop synchroniser. A pin change that is stable before clock edge k appears after edge k+1, whatever the direction setting.
- R5: When a line's mode bit (offset 0x30) and output bit are both 0, `irq[i]` equals the synchronised pin i.
- R6: When a line's mode bit is 0 and its output bit is 1, `irq[i]` equals the inverse of the synchronised pin i.
- R7: When a line's mode bit is 1, every rising or falling edge of the synchronised pin sets the pending bit, whatever the output bit holds. `irq[i]` then shows the pending bit and stays high while no register write occurs.
- R8: Writing a word to offset 0x38 clears the pending bit of each line whose bit is 1. Lines under 0 bits keep their pending bit. A detected edge in the same cycle as the acknowledge leaves the bit set.
- R9: Any write that changes a line's output bit or mode bit clears that line's pending bit at the same clock edge. This clear takes priority over an edge detected in that cycle.
- R10: Pins 16 to 31, and mode bits 16 to 31, have no effect on `irq`.
- R11: Reads at offsets 0x18, 0x20, 0x38 and at any unmapped offset return zero. Writes to unmapped offsets, or to offset 0x08, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Output drive value per pin |
| pin_oe | output | 32 | Output enable per pin, 1 = driven |
| irq | output | 16 | Active-high interrupt request per line |

## Verification
In both-edge mode, three actions can reach a line's pending bit at the same clock edge: a pin edge, an acknowledge write, and a configuration write. The bench times the pin change so that the synchronised edge is detected in exactly the cycle that carries the acknowledge write. The line must then stay high. In a second case, the write that enters both-edge mode lands on the edge cycle, and the line must stay low. A random phase follows that mixes register writes and pin toggles freely. Against a behavioural reference model, each line's level is compared with the expected value on every clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int REG_W  = 32;
   localparam int ADDR_W = 8;

   localparam logic [ADDR_W-1:0] OFF_DIR  = 8'h00;
   localparam logic [ADDR_W-1:0] OFF_IN   = 8'h08;
   localparam logic [ADDR_W-1:0] OFF_OUT  = 8'h10;
   localparam logic [ADDR_W-1:0] OFF_SET  = 8'h18;
   localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h20;
   localparam logic [ADDR_W-1:0] OFF_MODE = 8'h30;
   localparam logic [ADDR_W-1:0] OFF_ACK  = 8'h38;

   function automatic logic is_readable(logic [ADDR_W-1:0] a);
      return (a == OFF_DIR) || (a == OFF_IN) || (a == OFF_OUT) || (a == OFF_MODE);
   endfunction

   function automatic logic is_writable(logic [ADDR_W-1:0] a);
      return (a == OFF_DIR) || (a == OFF_OUT) || (a == OFF_SET) ||
             (a == OFF_CLR) || (a == OFF_MODE) || (a == OFF_ACK);
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) st_q[k] <= '0;
      end else begin
         st_q[0] <= d;
         for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
      end
   end

   assign q = st_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs import gpio_pkg::*; #(
   parameter int NUM_PINS = 32,
   parameter int NUM_IRQ  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [REG_W-1:0]    wdata,
   input  logic [NUM_PINS-1:0] sync_in,
   output logic [REG_W-1:0]    rdata,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] out_q,
   output logic [NUM_PINS-1:0] mode_q,
   output logic [NUM_IRQ-1:0]  cfg_clr,
   output logic [NUM_IRQ-1:0]  ack
);
   logic [NUM_PINS-1:0] wbits;
   logic [NUM_PINS-1:0] dir_nxt, out_nxt, mode_nxt, chg;

   assign wbits = wdata[NUM_PINS-1:0];

   always_comb begin
      dir_nxt  = dir_q;
      out_nxt  = out_q;
      mode_nxt = mode_q;
      if (we) begin
         case (addr)
            OFF_DIR:  dir_nxt  = wbits;
            OFF_OUT:  out_nxt  = wbits;
            OFF_SET:  out_nxt  = out_q | wbits;
            OFF_CLR:  out_nxt  = out_q & ~wbits;
            OFF_MODE: mode_nxt = wbits;
            default:  ;
         endcase
      end
   end

   // a line whose polarity or mode moves loses its pending edge
   assign chg     = (out_nxt ^ out_q) | (mode_nxt ^ mode_q);
   assign cfg_clr = chg[NUM_IRQ-1:0];
   assign ack     = (we && addr == OFF_ACK) ? wdata[NUM_IRQ-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         mode_q <= '0;
      end else begin
         dir_q  <= dir_nxt;
         out_q  <= out_nxt;
         mode_q <= mode_nxt;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         OFF_DIR:  rdata[NUM_PINS-1:0] = dir_q;
         OFF_IN:   rdata[NUM_PINS-1:0] = sync_in;
         OFF_OUT:  rdata[NUM_PINS-1:0] = out_q;
         OFF_MODE: rdata[NUM_PINS-1:0] = mode_q;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic pol,
   input  logic both,
   input  logic cfg_clr,
   input  logic ack,
   output logic irq_o
);
   logic prev_q, pend_q, edge_det;

   assign edge_det = pin_s ^ prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= pin_s;
         if (cfg_clr)               pend_q <= 1'b0;
         else if (both && edge_det) pend_q <= 1'b1;
         else if (ack)              pend_q <= 1'b0;
      end
   end

   assign irq_o = both ? pend_q : (pin_s ^ pol);
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq import gpio_pkg::*; #(
   parameter int NUM_PINS    = 32,
   parameter int NUM_IRQ     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [REG_W-1:0]    bus_wdata,
   output logic [REG_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_IRQ-1:0]  irq
);
   if (NUM_PINS > REG_W || NUM_PINS < 1) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..REG_W");
   end
   if (NUM_IRQ > NUM_PINS || NUM_IRQ < 1) begin : g_bad_irq
      $error("NUM_IRQ must lie in 1..NUM_PINS");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] sync_q, dir_q, out_q, mode_q;
   logic [NUM_IRQ-1:0]  cfg_clr, ack, irq_mode;

   gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
   );

   gpio_regs #(.NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .sync_in(sync_q), .rdata(bus_rdata), .dir_q(dir_q), .out_q(out_q),
      .mode_q(mode_q), .cfg_clr(cfg_clr), .ack(ack)
   );

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      gpio_irq_line u_line (
         .clk(clk), .rst_n(rst_n), .pin_s(sync_q[i]), .pol(out_q[i]),
         .both(mode_q[i]), .cfg_clr(cfg_clr[i]), .ack(ack[i]), .irq_o(irq[i])
      );
   end

   assign irq_mode = mode_q[NUM_IRQ-1:0];
   assign pin_out  = out_q;
   assign pin_oe   = dir_q;
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk import gpio_pkg::*; #(
   parameter int NUM_PINS = 32,
   parameter int NUM_IRQ  = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_we,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [REG_W-1:0]    bus_wdata,
   input logic [REG_W-1:0]    bus_rdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_IRQ-1:0]  irq,
   input logic [NUM_IRQ-1:0]  mode
);
   AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == OFF_DIR |=> pin_oe == $past(bus_wdata[NUM_PINS-1:0])); // R2
   AST_OUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == OFF_OUT |=> pin_out == $past(bus_wdata[NUM_PINS-1:0])); // R2
   AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == OFF_SET |=>
         pin_out == ($past(pin_out) | $past(bus_wdata[NUM_PINS-1:0]))); // R3
   AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == OFF_CLR |=>
         pin_out == ($past(pin_out) & ~$past(bus_wdata[NUM_PINS-1:0]))); // R3
   AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !is_readable(bus_addr) |-> bus_rdata == '0); // R11
   AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && !is_writable(bus_addr) |=> $stable(pin_out) && $stable(pin_oe)); // R11

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line_chk
      AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         mode[i] && irq[i] && !bus_we |=> irq[i]); // R7
      AST_MODE_ENTRY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
         bus_we && bus_addr == OFF_MODE && bus_wdata[i] && !mode[i] |=> !irq[i]); // R9
   end
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
   .pin_oe(pin_oe), .irq(irq), .mode(irq_mode)
);

// File: tb/gpio_bank_irq_tb.sv
`timescale 1ns/1ps
module gpio_bank_irq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0;
   logic [31:0] pin_in = '0;
   logic [31:0] bus_rdata, pin_out, pin_oe;
   logic [15:0] irq;

   int tests = 0, fails = 0, cyc = 0;
   bit done = 1'b0, cmp_en = 1'b0;
   logic [31:0] val;

   // behavioural reference state
   bit [31:0] m_s1, m_s2, m_prev, m_dir, m_out, m_mode, m_pend;

   always #2.5 clk = ~clk;

   gpio_bank_irq u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
      .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq(irq)
   );

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   function automatic bit [31:0] exp_irq();
      bit [31:0] r = '0;
      for (int i = 0; i < 16; i++)
         r[i] = m_mode[i] ? m_pend[i] : (m_s2[i] ^ m_out[i]);
      return r;
   endfunction

   function automatic bit [31:0] exp_rd(logic [7:0] a);
      case (a)
         8'h00:   return m_dir;
         8'h08:   return m_s2;
         8'h10:   return m_out;
         8'h30:   return m_mode;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0; m_dir = '0; m_out = '0; m_mode = '0; m_pend = '0;
      end else begin
         bit [31:0] n_out = m_out, n_mode = m_mode, n_dir = m_dir;
         if (we) begin
            if (addr == 8'h00) n_dir  = wdata;
            if (addr == 8'h10) n_out  = wdata;
            if (addr == 8'h18) n_out  = m_out | wdata;
            if (addr == 8'h20) n_out  = m_out & ~wdata;
            if (addr == 8'h30) n_mode = wdata;
         end
         for (int i = 0; i < 16; i++) begin
            if (n_out[i] != m_out[i] || n_mode[i] != m_mode[i]) m_pend[i] = 1'b0;
            else if (m_mode[i] && (m_s2[i] != m_prev[i]))       m_pend[i] = 1'b1;
            else if (we && addr == 8'h38 && wdata[i])           m_pend[i] = 1'b0;
         end
         m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
         m_out = n_out; m_mode = n_mode; m_dir = n_dir;
      end
   end

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         chk("R2 pin_oe", pin_oe, m_dir);
         chk("R2/R3 pin_out", pin_out, m_out);
         chk("R5/R6/R7/R8/R9/R10 irq", {16'h0, irq}, exp_irq());
         chk("R4/R11 rdata", bus_rdata, exp_rd(addr));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         tests++; fails++;
         $display("FAIL R1 watchdog got=%0d exp=<100000 cycles", cyc);
         finish_run();
      end
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk); #1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk); #1; we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] v);
      @(negedge clk); #1; addr = a; #1; v = bus_rdata;
   endtask

   task automatic setpin(logic [31:0] v);
      @(negedge clk); #1; pin_in = v;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1; rst_n = 1'b1;
      @(negedge clk); #1; cmp_en = 1'b1;

      // R1 reset state
      rd(8'h00, val); chk("R1 dir", val, 32'h0);
      rd(8'h10, val); chk("R1 out", val, 32'h0);
      rd(8'h30, val); chk("R1 mode", val, 32'h0);
      chk("R1 pin_oe", pin_oe, 32'h0);
      chk("R1 irq", {16'h0, irq}, 32'h0);

      // R2 direction and output words
      wr(8'h00, 32'hFFFF0000);
      wr(8'h10, 32'h12345678);
      chk("R2 pin_oe", pin_oe, 32'hFFFF0000);
      chk("R2 pin_out", pin_out, 32'h12345678);
      rd(8'h10, val); chk("R2 readback", val, 32'h12345678);

      // R3 set/clear
      wr(8'h18, 32'h0000000F); chk("R3 set", pin_out, 32'h1234567F);
      wr(8'h20, 32'h00000070); chk("R3 clear", pin_out, 32'h1234560F);
      rd(8'h18, val); chk("R11 set reads zero", val, 32'h0);
      rd(8'h20, val); chk("R11 clear reads zero", val, 32'h0);

      // R4 synchroniser latency
      wr(8'h10, 32'h0);
      setpin(32'hA5A50000);
      @(negedge clk); #1; addr = 8'h08; #1;
      chk("R4 not yet visible", bus_rdata, 32'h0);
      @(negedge clk); #1;
      chk("R4 visible", bus_rdata, 32'hA5A50000);
      chk("R10 upper pins", {16'h0, irq}, 32'h0);

      // R5 pass-through
      setpin(32'hA5A50008); idle(2);
      chk("R5 level high", {16'h0, irq}, 32'h00000008);

      // R6 inverted
      wr(8'h18, 32'h8);
      chk("R6 inverted high pin", {16'h0, irq}, 32'h0);
      setpin(32'hA5A50000); idle(2);
      chk("R6 inverted low pin", {16'h0, irq}, 32'h00000008);
      wr(8'h20, 32'h8);

      // R7 both edges, polarity ignored
      wr(8'h30, 32'h20);
      wr(8'h18, 32'h20);
      chk("R7 no pending", {16'h0, irq}, 32'h0);
      setpin(32'hA5A50020); idle(3);
      chk("R7 rising", {16'h0, irq}, 32'h20);
      setpin(32'hA5A50000); idle(5);
      chk("R7 sticky", {16'h0, irq}, 32'h20);

      // R8 acknowledge
      wr(8'h38, 32'h0000FFDF);
      chk("R8 zero bits keep", {16'h0, irq}, 32'h20);
      wr(8'h38, 32'h20);
      chk("R8 ack clears", {16'h0, irq}, 32'h0);
      setpin(32'hA5A50020);
      @(negedge clk); #1;
      @(negedge clk); #1; we = 1'b1; addr = 8'h38; wdata = 32'h20;
      @(negedge clk); #1; we = 1'b0;
      chk("R8 edge beats ack", {16'h0, irq}, 32'h20);
      wr(8'h38, 32'h20);

      // R9 configuration change clears
      setpin(32'hA5A50000); idle(3);
      chk("R9 pending set", {16'h0, irq}, 32'h20);
      wr(8'h20, 32'h20);
      chk("R9 polarity change clears", {16'h0, irq}, 32'h0);
      setpin(32'hA5A50040);
      @(negedge clk); #1;
      @(negedge clk); #1; we = 1'b1; addr = 8'h30; wdata = 32'h60;
      @(negedge clk); #1; we = 1'b0;
      chk("R9 mode write beats edge", {16'h0, irq}, 32'h0);
      setpin(32'hA5A50000); idle(3);
      chk("R7 falling", {16'h0, irq}, 32'h40);

      // R10 upper pins and mode bits
      wr(8'h30, 32'hFFFF0060);
      setpin(32'h5A5A0000); idle(4);
      chk("R10 upper no effect", {16'h0, irq}, 32'h40);

      // R11 unmapped
      rd(8'h04, val); chk("R11 unmapped 04", val, 32'h0);
      rd(8'h28, val); chk("R11 unmapped 28", val, 32'h0);
      rd(8'h38, val); chk("R11 ack reads zero", val, 32'h0);
      wr(8'h28, 32'hFFFFFFFF);
      wr(8'h08, 32'hFFFFFFFF);
      rd(8'h00, val); chk("R11 dir kept", val, 32'hFFFF0000);
      rd(8'h10, val); chk("R11 out kept", val, 32'h0);
      rd(8'h30, val); chk("R11 mode kept", val, 32'hFFFF0060);

      // random mixing against the reference model
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk); #1;
         we = ($urandom_range(0, 1) == 1);
         case ($urandom_range(0, 7))
            0: addr = 8'h00;  1: addr = 8'h08;  2: addr = 8'h10;  3: addr = 8'h18;
            4: addr = 8'h20;  5: addr = 8'h30;  6: addr = 8'h38;  default: addr = 8'h28;
         endcase
         wdata = $urandom();
         if ($urandom_range(0, 3) == 0) pin_in = pin_in ^ (32'h1 << $urandom_range(0, 31));
      end
      @(negedge clk); #1; we = 1'b0;
      idle(4);
      finish_run();
   end
endmodule